// File: doc/BRIEF.md
# Layer Coincidence Track Classifier

This block sorts drift-chamber track candidates per azimuthal sector. Each of `N_SECT` sectors reports one segment-found bit per superlayer: SL3, SL4, SL7 and SL11. Two coincidence rules run side by side on every sector.

A long track is anchored on SL11. It needs SL11 plus enough of the three inner layers to reach a selectable majority: 3-of-4 or 4-of-4. A short track is anchored on SL7. It needs SL7, SL4 and SL3 all present. A sector that qualifies as long is never also reported as short.

The block counts the sectors carrying each flag and saturates each count at its register limit. The per-sector flags and the two counts leave the block together on a valid strobe.

The datapath is a two-stage pipeline with no dead time. A new sector vector set can arrive with `in_valid` on every clock. The block has no ready signal and never applies back-pressure. A beat that enters always leaves exactly two clocks later, so a downstream consumer must be able to take a beat on every cycle that `out_valid` is high.

Top module: `layer_track_classifier`

## Requirements
- R1: With the majority mode at 0 (3-of-4), a sector's long flag is set exactly when SL11 is set and at least two of SL7, SL4 and SL3 are set.
- R2: With the majority mode at 1 (4-of-4), a sector's long flag is set exactly when all of SL11, SL7, SL4 and SL3 are set.
- R3: A sector's short flag is set exactly when SL7, SL4 and SL3 are all set and its long flag is clear; long and short are never both set for one sector.
- R4: `mode_all4` is registered. A beat accepted at clock edge t is classified with the mode value sampled at edge t-1, so a change applied together with a beat affects only the following beats.
- R5: A beat accepted at edge t appears on the outputs after edge t+1, and `out_valid` is then high. `out_valid` equals `in_valid` delayed by two clocks.
- R6: Beats may arrive on consecutive clocks with no gaps, and each one is reported in order with no loss.
- R7: `long_cnt` and `short_cnt` equal the number of sectors whose long or short flag is set, saturating at 2^CNT_W-1.
- R8: A cycle with `in_valid` low produces, two clocks later, `out_valid` low with all flags and both counts zero, whatever the segment inputs were.
- R9: Synchronous reset (`rst` high at a clock edge) clears the pipeline, `out_valid`, the flags, the counts and the registered mode (to 3-of-4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam-synchronous pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_all4 | input | 1 | Long-track majority: 0 = 3-of-4, 1 = 4-of-4 |
| in_valid | input | 1 | Sector vector set valid this cycle |
| seg_sl3 | input | N_SECT | Segment-found bit per sector, SL3 |
| seg_sl4 | input | N_SECT | Segment-found bit per sector, SL4 |
| seg_sl7 | input | N_SECT | Segment-found bit per sector, SL7 |
| seg_sl11 | input | N_SECT | Segment-found bit per sector, SL11 |
| out_valid | output | 1 | Result valid strobe |
| long_flags | output | N_SECT | Long-track flag per sector |
| short_flags | output | N_SECT | Short-track flag per sector |
| long_cnt | output | CNT_W | Saturating count of long sectors |
| short_cnt | output | CNT_W | Saturating count of short sectors |

## Verification
On every cycle the assertions check several properties:
- long and short never coincide in one sector;
- every long or short flag is backed by the segment bits seen two clocks earlier;
- `out_valid` follows `in_valid` at a fixed two-clock delay;
- idle beats come out empty;
- each count matches the population of its flag vector, clipped at the limit.

Only the bench scenarios can show the rest:
- each rule fires in every sector where it should, not just that it never fires wrongly;
- a mode change applies one beat late;
- back-to-back beats stay in order;
- saturation is reached on a narrow-count instance;
- a mid-stream reset clears everything.

// File: rtl/lct_pkg.sv
package lct_pkg;
  typedef enum logic {
    MAJ_3OF4 = 1'b0,
    MAJ_4OF4 = 1'b1
  } maj_mode_e;
endpackage

// File: rtl/lct_sector_rule.sv
module lct_sector_rule
  import lct_pkg::*;
(
  input  logic      hit_sl3,
  input  logic      hit_sl4,
  input  logic      hit_sl7,
  input  logic      hit_sl11,
  input  maj_mode_e maj,
  output logic      is_long,
  output logic      is_short
);
  logic [1:0] inner_hits;
  logic       inner_ok;

  always_comb begin
    inner_hits = 2'(hit_sl3) + 2'(hit_sl4) + 2'(hit_sl7);
    if (maj == MAJ_4OF4) inner_ok = (inner_hits == 2'd3);
    else                 inner_ok = (inner_hits >= 2'd2);
    is_long  = hit_sl11 & inner_ok;
    is_short = hit_sl7 & hit_sl4 & hit_sl3 & ~is_long;
  end
endmodule

// File: rtl/lct_sat_count.sv
module lct_sat_count #(
  parameter int N_SECT = 16,
  parameter int CNT_W  = 5
) (
  input  logic [N_SECT-1:0] flags,
  output logic [CNT_W-1:0]  cnt
);
  localparam int MAX_V = (1 << CNT_W) - 1;
  int sum;

  always_comb begin
    sum = 0;
    for (int i = 0; i < N_SECT; i++) sum += int'(flags[i]);
    cnt = (sum > MAX_V) ? CNT_W'(MAX_V) : CNT_W'(sum);
  end
endmodule

// File: rtl/layer_track_classifier.sv
module layer_track_classifier
  import lct_pkg::*;
#(
  parameter int N_SECT = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_all4,
  input  logic              in_valid,
  input  logic [N_SECT-1:0] seg_sl3,
  input  logic [N_SECT-1:0] seg_sl4,
  input  logic [N_SECT-1:0] seg_sl7,
  input  logic [N_SECT-1:0] seg_sl11,
  output logic              out_valid,
  output logic [N_SECT-1:0] long_flags,
  output logic [N_SECT-1:0] short_flags,
  output logic [CNT_W-1:0]  long_cnt,
  output logic [CNT_W-1:0]  short_cnt
);
  maj_mode_e         maj_q;
  logic [N_SECT-1:0] long_c, short_c;
  logic [N_SECT-1:0] long_s1, short_s1;
  logic              vld_s1;
  logic [CNT_W-1:0]  long_cnt_c, short_cnt_c;

  // Mode register: beats use the value sampled one edge earlier.
  always_ff @(posedge clk) begin
    if (rst) maj_q <= MAJ_3OF4;
    else     maj_q <= maj_mode_e'(mode_all4);
  end

  for (genvar g = 0; g < N_SECT; g++) begin : g_sector
    lct_sector_rule u_rule (
      .hit_sl3  (seg_sl3[g]),
      .hit_sl4  (seg_sl4[g]),
      .hit_sl7  (seg_sl7[g]),
      .hit_sl11 (seg_sl11[g]),
      .maj      (maj_q),
      .is_long  (long_c[g]),
      .is_short (short_c[g])
    );
  end

  // Stage 1: per-sector flags, emptied on idle beats.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1   <= 1'b0;
      long_s1  <= '0;
      short_s1 <= '0;
    end else begin
      vld_s1   <= in_valid;
      long_s1  <= in_valid ? long_c  : '0;
      short_s1 <= in_valid ? short_c : '0;
    end
  end

  lct_sat_count #(.N_SECT(N_SECT), .CNT_W(CNT_W)) u_cnt_long (
    .flags (long_s1),
    .cnt   (long_cnt_c)
  );

  lct_sat_count #(.N_SECT(N_SECT), .CNT_W(CNT_W)) u_cnt_short (
    .flags (short_s1),
    .cnt   (short_cnt_c)
  );

  // Stage 2: counts aligned with their flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      long_flags  <= '0;
      short_flags <= '0;
      long_cnt    <= '0;
      short_cnt   <= '0;
    end else begin
      out_valid   <= vld_s1;
      long_flags  <= long_s1;
      short_flags <= short_s1;
      long_cnt    <= long_cnt_c;
      short_cnt   <= short_cnt_c;
    end
  end
endmodule

// File: rtl/lct_checker.sv
module lct_checker #(
  parameter int N_SECT = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [N_SECT-1:0] seg_sl3,
  input logic [N_SECT-1:0] seg_sl4,
  input logic [N_SECT-1:0] seg_sl7,
  input logic [N_SECT-1:0] seg_sl11,
  input logic              out_valid,
  input logic [N_SECT-1:0] long_flags,
  input logic [N_SECT-1:0] short_flags,
  input logic [CNT_W-1:0]  long_cnt,
  input logic [CNT_W-1:0]  short_cnt
);
  localparam int MAX_V = (1 << CNT_W) - 1;
  logic [1:0]        age;
  logic [N_SECT-1:0] maj_in, all3_in;

  always_ff @(posedge clk) begin
    if (rst)             age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign maj_in  = (seg_sl11 & seg_sl7 & seg_sl4) | (seg_sl11 & seg_sl7 & seg_sl3)
                 | (seg_sl11 & seg_sl4 & seg_sl3);
  assign all3_in = seg_sl7 & seg_sl4 & seg_sl3;

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    (long_flags & short_flags) == '0);

  assert_short_backed_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> ((short_flags & ~$past(all3_in, 2)) == '0));

  assert_long_backed_R1: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> ((long_flags & ~$past(maj_in, 2)) == '0));

  assert_valid_delay_R5: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_idle_empty_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (long_flags == '0 && short_flags == '0 && long_cnt == '0 && short_cnt == '0));

  assert_long_count_R7: assert property (@(posedge clk) disable iff (rst)
    int'(long_cnt) == (($countones(long_flags) > MAX_V) ? MAX_V : $countones(long_flags)));

  assert_short_count_R7: assert property (@(posedge clk) disable iff (rst)
    int'(short_cnt) == (($countones(short_flags) > MAX_V) ? MAX_V : $countones(short_flags)));
endmodule

bind layer_track_classifier lct_checker #(.N_SECT(N_SECT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .seg_sl3     (seg_sl3),
  .seg_sl4     (seg_sl4),
  .seg_sl7     (seg_sl7),
  .seg_sl11    (seg_sl11),
  .out_valid   (out_valid),
  .long_flags  (long_flags),
  .short_flags (short_flags),
  .long_cnt    (long_cnt),
  .short_cnt   (short_cnt)
);

// File: tb/layer_track_classifier_tb.sv
module layer_track_classifier_tb;
  localparam int CLK_P = 10;
  localparam int NS    = 16;
  localparam int CW    = 5;
  localparam int CW_S  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_all4 = 1'b0;
  logic          in_valid = 1'b0;
  logic [NS-1:0] s3 = '0, s4 = '0, s7 = '0, s11 = '0;
  logic          out_valid, sat_valid;
  logic [NS-1:0] long_flags, short_flags, sat_long_f, sat_short_f;
  logic [CW-1:0] long_cnt, short_cnt;
  logic [CW_S-1:0] sat_long_cnt, sat_short_cnt;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  layer_track_classifier #(.N_SECT(NS), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .mode_all4(mode_all4), .in_valid(in_valid),
    .seg_sl3(s3), .seg_sl4(s4), .seg_sl7(s7), .seg_sl11(s11),
    .out_valid(out_valid), .long_flags(long_flags), .short_flags(short_flags),
    .long_cnt(long_cnt), .short_cnt(short_cnt)
  );

  layer_track_classifier #(.N_SECT(NS), .CNT_W(CW_S)) u_sat (
    .clk(clk), .rst(rst), .mode_all4(mode_all4), .in_valid(in_valid),
    .seg_sl3(s3), .seg_sl4(s4), .seg_sl7(s7), .seg_sl11(s11),
    .out_valid(sat_valid), .long_flags(sat_long_f), .short_flags(sat_short_f),
    .long_cnt(sat_long_cnt), .short_cnt(sat_short_cnt)
  );

  function automatic int clip(int v, int w);
    return (v > (1 << w) - 1) ? (1 << w) - 1 : v;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare outputs with a model of the beat (vld, vectors, mode in force).
  task automatic check_beat(string req, logic vld, logic [NS-1:0] a3, a4, a7, a11, logic m4);
    logic [NS-1:0] el = '0, es = '0;
    int nl = 0, ns = 0;
    for (int i = 0; i < NS; i++) begin
      int inner = int'(a3[i]) + int'(a4[i]) + int'(a7[i]);
      logic lg = vld && a11[i] && (m4 ? inner == 3 : inner >= 2);
      logic sh = vld && a3[i] && a4[i] && a7[i] && !lg;
      el[i] = lg; es[i] = sh;
      nl += int'(lg); ns += int'(sh);
    end
    cmp(req, "out_valid", int'(out_valid), int'(vld));
    cmp(req, "long_flags", int'(long_flags), int'(el));
    cmp(req, "short_flags", int'(short_flags), int'(es));
    cmp(req, "long_cnt", int'(long_cnt), clip(nl, CW));
    cmp(req, "short_cnt", int'(short_cnt), clip(ns, CW));
    cmp(req, "sat long_cnt", int'(sat_long_cnt), clip(nl, CW_S));
    cmp(req, "sat short_cnt", int'(sat_short_cnt), clip(ns, CW_S));
  endtask

  task automatic drive(logic v, logic [NS-1:0] a3, a4, a7, a11);
    in_valid = v; s3 = a3; s4 = a4; s7 = a7; s11 = a11;
  endtask

  // One isolated beat, checked two edges later.
  task automatic single(string req, logic [NS-1:0] a3, a4, a7, a11, logic m4);
    drive(1'b1, a3, a4, a7, a11);
    @(negedge clk);
    drive(1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check_beat(req, 1'b1, a3, a4, a7, a11, m4);
  endtask

  task automatic set_mode(logic m);
    mode_all4 = m;
    @(negedge clk);
  endtask

  task automatic t_reset();  // R9
    check_beat("R9", 1'b0, '0, '0, '0, '0, 1'b0);
  endtask

  task automatic t_long_3of4();  // R1
    set_mode(1'b0);
    single("R1", 16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00, 1'b0);
    single("R1", 16'h0F0F, 16'h3333, 16'h5555, 16'hFFFF, 1'b0);
  endtask

  task automatic t_long_4of4();  // R2
    set_mode(1'b1);
    single("R2", 16'hAAAA, 16'hCCCC, 16'hF0F0, 16'hFF00, 1'b1);
    single("R2", 16'hFFFF, 16'hFFFF, 16'hFFF0, 16'h0FFF, 1'b1);
    set_mode(1'b0);
  endtask

  task automatic t_short();  // R3
    single("R3", 16'h00FF, 16'h00FF, 16'h00FF, 16'h000F, 1'b0);
    set_mode(1'b1);
    single("R3", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h00FF, 1'b1);
    set_mode(1'b0);
  endtask

  task automatic t_mode_timing();  // R4
    // Mode flips together with the beat: the old mode (3-of-4) still applies.
    mode_all4 = 1'b1;
    single("R4", 16'h00FF, 16'h0F0F, 16'hFFFF, 16'hFFFF, 1'b0);
    // The next beat sees 4-of-4.
    single("R4", 16'h00FF, 16'h0F0F, 16'hFFFF, 16'hFFFF, 1'b1);
    set_mode(1'b0);
  endtask

  task automatic t_stream();  // R5 R6
    drive(1'b1, 16'h1111, 16'h1111, 16'h1111, 16'h1111);
    @(negedge clk);
    drive(1'b1, 16'h2222, 16'h2222, 16'h2222, 16'h0000);
    @(negedge clk);
    check_beat("R5", 1'b1, 16'h1111, 16'h1111, 16'h1111, 16'h1111, 1'b0);
    drive(1'b1, 16'h4444, 16'h0000, 16'h4444, 16'h4444);
    @(negedge clk);
    check_beat("R6", 1'b1, 16'h2222, 16'h2222, 16'h2222, 16'h0000, 1'b0);
    drive(1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check_beat("R6", 1'b1, 16'h4444, 16'h0000, 16'h4444, 16'h4444, 1'b0);
    @(negedge clk);
    check_beat("R5", 1'b0, '0, '0, '0, '0, 1'b0);
  endtask

  task automatic t_idle();  // R8
    drive(1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    @(negedge clk);
    check_beat("R8", 1'b0, '0, '0, '0, '0, 1'b0);
    drive(1'b0, '0, '0, '0, '0);
  endtask

  task automatic t_saturate();  // R7
    single("R7", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    single("R7", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0);
    single("R7", 16'h00FF, 16'h00FF, 16'h00FF, 16'h00FF, 1'b0);
  endtask

  task automatic t_midreset();  // R9
    mode_all4 = 1'b1;
    drive(1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    @(negedge clk);
    rst = 1'b1;
    mode_all4 = 1'b0;
    @(negedge clk);
    check_beat("R9", 1'b0, '0, '0, '0, '0, 1'b0);
    rst = 1'b0;
    // Registered mode returned to 3-of-4 by reset even though mode_all4 was 1.
    drive(1'b1, 16'h0000, 16'h00FF, 16'h00FF, 16'h00FF);
    mode_all4 = 1'b1;
    @(negedge clk);
    drive(1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check_beat("R9", 1'b1, 16'h0000, 16'h00FF, 16'h00FF, 16'h00FF, 1'b0);
    set_mode(1'b0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_long_3of4();
    t_long_4of4();
    t_short();
    t_mode_timing();
    t_stream();
    t_idle();
    t_saturate();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule